// File: doc/BRIEF.md
# Register-Pool Parallel Mersenne Twister

This block is a 32-bit MT19937 uniform random number generator whose whole 624-word state is held in flip-flops. A parameter `LANES` sets how many twist-and-temper units run side by side. Each clock, while the block is running, every lane produces one new state word and one tempered output word, so `LANES` fresh 32-bit numbers appear per cycle. The state is kept as a rotating window that always holds the newest 624 words in sequence order. Each lane is therefore wired to fixed window positions, and no address logic exists anywhere.

After reset the block seeds itself from a default seed of 5489. A `seed_load` pulse restarts seeding from any 32-bit value. Seeding runs one word per clock, and `ready` rises when the pool is complete. From then on `rnd_valid` is high every cycle, and `rnd_data` carries the next `LANES` words of the sequential generator's stream, in order. When `LANES` exceeds 227, some lanes need a far operand that another lane is producing in the same cycle. Those lanes take the freshly computed value from that lane through a short combinational forward.

Top module: `mtw_multilane`

## Requirements
- R1: While `rst` is high, and after it until seeding completes, `ready` and `rnd_valid` are low. Reset alone starts seeding from seed 5489.
- R2: `ready` rises exactly 624 rising edges after the last edge with `rst` high, or after the edge that samples `seed_load` high. It then stays high until the next reset or load.
- R3: `rnd_valid` is high in the cycle after every cycle in which `ready` is high and `seed_load` is low, and is low otherwise.
- R4: `rnd_data` word k (bits 32k+31 down to 32k) equals the MT19937 output number at sequence position k within the cycle. For seed 5489 the first word after `rnd_valid` rises is 0xD091BB5C.
- R5: Consecutive valid cycles continue the stream without gap or repeat, including across every 624-word boundary.
- R6: A `seed_load` sampled high forces `ready` and `rnd_valid` low on the next cycle. Seeding then restarts from `seed_value`, and the stream that follows is the one for that seed.
- R7: A load that arrives while seeding is still in progress discards the partial pool and restarts the full 624-cycle count.
- R8: With `LANES` above 227, a lane whose far operand is being produced in the same cycle uses the new value. Its outputs still match the sequential stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Restart seeding from `seed_value` |
| seed_value | input | 32 | Seed taken when `seed_load` is high |
| ready | output | 1 | State pool is seeded and the generator is running |
| rnd_valid | output | 1 | `rnd_data` holds fresh numbers this cycle |
| rnd_data | output | 32*LANES | Output words, word k at bits 32k+31:32k |

## Verification
The assertions assume that `rst` is synchronous and held for at least one edge, and they are suspended while it is high. They also assume that `seed_load` may arrive in any cycle, including during seeding, and that its sampled value alone decides what follows. The stimulus changes every input on the falling edge, so each rising edge sees stable values. It issues loads both while the generator is running and partway through a seeding pass. Output values are compared against a sequential model of the generator kept in the bench. The bench runs a lane count above 227 so that the same-cycle forward path is exercised.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
  localparam int unsigned MT_WORDS = 624;
  localparam int unsigned MT_FAR   = 397;
  localparam int unsigned MT_WRAP  = MT_WORDS - MT_FAR;
  localparam int unsigned MT_CW    = $clog2(MT_WORDS + 1);

  // one twist step: low-order word bits from nxt, top bit from cur
  function automatic logic [31:0] mt_mix(input logic [31:0] cur,
                                         input logic [31:0] nxt,
                                         input logic [31:0] far);
    logic [31:0] joined;
    joined = {cur[31], nxt[30:0]};
    return far ^ {1'b0, joined[31:1]} ^ (joined[0] ? 32'h9908B0DF : 32'h0);
  endfunction

  // output tempering of one state word
  function automatic logic [31:0] mt_temper(input logic [31:0] w);
    logic [31:0] t;
    t = w ^ (w >> 11);
    t = t ^ ((t << 7) & 32'h9D2C5680);
    t = t ^ ((t << 15) & 32'hEFC60000);
    return t ^ (t >> 18);
  endfunction

  // seeding recurrence: word idx from word idx-1
  function automatic logic [31:0] mt_seed_next(input logic [31:0] prev,
                                               input logic [31:0] idx);
    return 32'd1812433253 * (prev ^ (prev >> 30)) + idx;
  endfunction
endpackage

// File: rtl/mtw_seeder.sv
module mtw_seeder
  import mtw_pkg::*;
#(
  parameter logic [31:0] SEED0 = 32'd5489
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] load_value,
  output logic [31:0] seed_word,
  output logic        seed_shift,
  output logic        ready
);
  localparam logic [MT_CW-1:0] LAST = MT_CW'(MT_WORDS - 1);

  logic [31:0]      cur_q;
  logic [MT_CW-1:0] cnt_q;
  logic             ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= SEED0;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (load) begin
      cur_q   <= load_value;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      cur_q <= mt_seed_next(cur_q, 32'(cnt_q) + 32'd1);
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) ready_q <= 1'b1;
    end
  end

  assign seed_word  = cur_q;
  assign seed_shift = !rst && !load && !ready_q;
  assign ready      = ready_q;
endmodule

// File: rtl/mtw_state_pool.sv
module mtw_state_pool
  import mtw_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned HEAD_N = (LANES + 1 < MT_WORDS) ? LANES + 1 : MT_WORDS,
  parameter int unsigned FAR_N  = (LANES < MT_WRAP) ? LANES : MT_WRAP
) (
  input  logic                  clk,
  input  logic                  shift_seed,
  input  logic                  shift_run,
  input  logic [31:0]           tail_word,
  input  logic [LANES*32-1:0]   fresh,
  output logic [HEAD_N*32-1:0]  head,
  output logic [FAR_N*32-1:0]   far
);
  // st[p] holds the word p places after the oldest one still needed
  logic [31:0] st [MT_WORDS];

  for (genvar p = 0; p < MT_WORDS; p++) begin : g_cell
    logic [31:0] run_src, seed_src;
    if (p + LANES < MT_WORDS) begin : g_run_shift
      assign run_src = st[p + LANES];
    end else begin : g_run_fresh
      assign run_src = fresh[(p + LANES - MT_WORDS)*32 +: 32];
    end
    if (p + 1 < MT_WORDS) begin : g_seed_shift
      assign seed_src = st[p + 1];
    end else begin : g_seed_tail
      assign seed_src = tail_word;
    end
    always_ff @(posedge clk) begin
      if (shift_run)       st[p] <= run_src;
      else if (shift_seed) st[p] <= seed_src;
    end
  end

  for (genvar h = 0; h < HEAD_N; h++) begin : g_head
    assign head[h*32 +: 32] = st[h];
  end
  for (genvar f = 0; f < FAR_N; f++) begin : g_far
    assign far[f*32 +: 32] = st[f + MT_FAR];
  end
endmodule

// File: rtl/mtw_lane.sv
module mtw_lane
  import mtw_pkg::*;
(
  input  logic [31:0] w_cur,
  input  logic [31:0] w_next,
  input  logic [31:0] w_far,
  output logic [31:0] fresh,
  output logic [31:0] rnd
);
  assign fresh = mt_mix(w_cur, w_next, w_far);
  assign rnd   = mt_temper(fresh);
endmodule

// File: rtl/mtw_multilane.sv
module mtw_multilane
  import mtw_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter logic [31:0] SEED0 = 32'd5489
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                seed_load,
  input  logic [31:0]         seed_value,
  output logic                ready,
  output logic                rnd_valid,
  output logic [LANES*32-1:0] rnd_data
);
  localparam int unsigned HEAD_N = (LANES + 1 < MT_WORDS) ? LANES + 1 : MT_WORDS;
  localparam int unsigned FAR_N  = (LANES < MT_WRAP) ? LANES : MT_WRAP;

  logic [31:0]          seed_word;
  logic                 seed_shift;
  logic                 run_step;
  logic [HEAD_N*32-1:0] head_w;
  logic [FAR_N*32-1:0]  far_w;
  logic [LANES*32-1:0]  fresh_all;
  logic [LANES*32-1:0]  rnd_next;

  mtw_seeder #(.SEED0(SEED0)) u_seed (
    .clk        (clk),
    .rst        (rst),
    .load       (seed_load),
    .load_value (seed_value),
    .seed_word  (seed_word),
    .seed_shift (seed_shift),
    .ready      (ready)
  );

  assign run_step = ready && !seed_load && !rst;

  mtw_state_pool #(.LANES(LANES), .HEAD_N(HEAD_N), .FAR_N(FAR_N)) u_pool (
    .clk        (clk),
    .shift_seed (seed_shift),
    .shift_run  (run_step),
    .tail_word  (seed_word),
    .fresh      (fresh_all),
    .head       (head_w),
    .far        (far_w)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [31:0] w_a, w_b, w_c, nword, tword;
    assign w_a = head_w[j*32 +: 32];
    if (j + 1 < MT_WORDS) begin : g_next_pool
      assign w_b = head_w[(j+1)*32 +: 32];
    end else begin : g_next_fwd
      assign w_b = g_lane[0].nword;
    end
    if (j < MT_WRAP) begin : g_far_pool
      assign w_c = far_w[j*32 +: 32];
    end else begin : g_far_fwd
      assign w_c = g_lane[j - MT_WRAP].nword;
    end
    mtw_lane u_lane (
      .w_cur  (w_a),
      .w_next (w_b),
      .w_far  (w_c),
      .fresh  (nword),
      .rnd    (tword)
    );
    assign fresh_all[j*32 +: 32] = nword;
    assign rnd_next[j*32 +: 32]  = tword;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_valid <= 1'b0;
      rnd_data  <= '0;
    end else begin
      rnd_valid <= run_step;
      if (run_step) rnd_data <= rnd_next;
    end
  end
endmodule

// File: rtl/mtw_multilane_chk.sv
module mtw_multilane_chk
  import mtw_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic seed_load,
  input logic ready,
  input logic rnd_valid,
  input logic run_step,
  input logic seed_shift
);
  logic [MT_CW:0] since_start;

  always_ff @(posedge clk) begin
    if (rst || seed_load) since_start <= '0;
    else if (since_start != '1) since_start <= since_start + 1'b1;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!ready && !rnd_valid));

  p_seed_window_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (since_start == (MT_CW+1)'(MT_WORDS)));

  p_ready_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (ready && !seed_load) |=> ready);

  p_one_mode_r2: assert property (@(posedge clk) disable iff (rst)
    !(run_step && seed_shift));

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (ready && !seed_load) |=> rnd_valid);

  p_valid_needs_ready_r3: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |-> $past(ready));

  p_load_quiets_r6: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (!ready && !rnd_valid));
endmodule

bind mtw_multilane mtw_multilane_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .seed_load  (seed_load),
  .ready      (ready),
  .rnd_valid  (rnd_valid),
  .run_step   (run_step),
  .seed_shift (seed_shift)
);

// File: tb/sim_mtw_multilane.sv
module sim_mtw_multilane;
  localparam int LANES = 312;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst = 1'b1;
  logic                seed_load = 1'b0;
  logic [31:0]         seed_value = '0;
  logic                ready, rnd_valid;
  logic [LANES*32-1:0] rnd_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] ref_mt [624];
  int          ref_idx;

  mtw_multilane #(.LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .ready(ready), .rnd_valid(rnd_valid), .rnd_data(rnd_data)
  );

  // sequential reference generator, refilled one whole block at a time
  function automatic void ref_seed(input logic [31:0] s);
    ref_mt[0] = s;
    for (int i = 1; i < 624; i++)
      ref_mt[i] = 32'd1812433253 * (ref_mt[i-1] ^ (ref_mt[i-1] >> 30)) + 32'(i);
    ref_idx = 624;
  endfunction

  function automatic logic [31:0] ref_next();
    logic [31:0] v, a, b, c, d;
    if (ref_idx >= 624) begin
      for (int k = 0; k < 624; k++) begin
        logic [31:0] y;
        y = (ref_mt[k] & 32'h80000000) | (ref_mt[(k + 1) % 624] & 32'h7FFFFFFF);
        ref_mt[k] = ref_mt[(k + 397) % 624] ^ (y >> 1) ^ (y[0] ? 32'h9908B0DF : 32'h0);
      end
      ref_idx = 0;
    end
    v = ref_mt[ref_idx];
    ref_idx++;
    a = v ^ (v >> 11);
    b = a ^ ((a << 7) & 32'h9D2C5680);
    c = b ^ ((b << 15) & 32'hEFC60000);
    d = c ^ (c >> 18);
    return d;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ready && n < 3000);
  endtask

  // compares cycles of output against the model; sampled on falling edges
  task automatic compare_stream(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      check("R3 valid", 32'(rnd_valid), 32'd1);
      for (int k = 0; k < LANES; k++) begin
        logic [31:0] exp;
        exp = ref_next();
        if (k >= 227)   check("R8 forwarded lane", rnd_data[k*32 +: 32], exp);
        else if (c > 0) check("R5 continuation", rnd_data[k*32 +: 32], exp);
        else            check("R4 lane order", rnd_data[k*32 +: 32], exp);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check("R1 ready in reset", 32'(ready), 32'd0);
    check("R1 valid in reset", 32'(rnd_valid), 32'd0);

    rst = 1'b0;
    wait_ready(n);
    check("R2 seeding edges after reset", 32'(n), 32'd624);
    check("R1 valid before run", 32'(rnd_valid), 32'd0);
    ref_seed(32'd5489);
    @(negedge clk);
    check("R1 default seed first word", rnd_data[31:0], 32'hD091BB5C);
    compare_stream(6);
    check("R2 ready held", 32'(ready), 32'd1);

    // load while running
    seed_value = 32'h12345678;
    seed_load  = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    check("R6 ready after load", 32'(ready), 32'd0);
    check("R6 valid after load", 32'(rnd_valid), 32'd0);
    repeat (100) @(negedge clk);
    check("R7 still seeding", 32'(ready), 32'd0);

    // load again partway through seeding
    seed_value = 32'd42;
    seed_load  = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    wait_ready(n);
    check("R7 restarted seeding edges", 32'(n), 32'd624);
    ref_seed(32'd42);
    @(negedge clk);
    compare_stream(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule